// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit sits beside an 8-bit processor core and decides which of five interrupt requests the core services next. One request is non-maskable. Three carry fixed restart addresses and can be disabled one by one. The fifth asks the core to take one instruction from the external data bus, and it has no address of its own. Selection uses a fixed priority. Every source except the non-maskable one is also gated by a global enable flag.

The core pulses `boundary` between instructions. On that cycle, if no earlier decision is still waiting, the unit latches the winning request into a result register. The register drives `take_valid`, `take_vector`, `take_push` and `take_fetch` until the core pulses `take_ack`. The core itself saves the program counter and makes the jump. Software changes the per-source disable bits with a one-cycle register write. It sets or clears the global enable with two command strobes. It reads the current state back through `status`.

Top module: `vint_unit`

## Requirements
- R1: After reset, `take_valid` is 0, all three disable bits are 1, and the global enable is 0. With every request low, `status` reads 7'b000_0111.
- R2: `req_nmi` is taken when it rose while the unit watched it and is still high at a boundary. It ignores the disable bits and the global enable. It gives vector 16'h0024 with `take_push`=1. A request held high is taken only once. A pulse that falls before the boundary is not taken.
- R3: The three vectored maskable sources give these vectors, each with `take_push`=1 and `take_fetch`=0: `req_lo` gives 16'h002C, `req_mid` gives 16'h0034, `req_edge` gives 16'h003C.
- R4: Accepting `req_bus` sets `take_fetch`=1 and `take_push`=0, with `take_vector`=16'h0000. A valid result always has exactly one of `take_push` and `take_fetch` set.
- R5: Priority from highest to lowest is `req_nmi`, `req_edge`, `req_mid`, `req_lo`, `req_bus`. Only one request is accepted per boundary. A latched edge request that loses stays pending.
- R6: A cycle with `mask_we`=1 loads `mask_wdata[2:0]` into the disable bits: bit 0 for `req_lo`, bit 1 for `req_mid`, bit 2 for `req_edge`. A 1 blocks that source. `req_bus` and `req_nmi` ignore these bits.
- R7: The global enable gates the bus source and the three vectored maskable sources. Accepting any of these four clears it. `ie_set` sets it and `ie_clr` clears it. Accepting `req_nmi` leaves it unchanged.
- R8: A rising edge on `req_edge` sets a pending latch even while that source is disabled. The latch is cleared when the request is accepted, or by a mask write with `mask_wdata[3]`=1.
- R9: `req_lo`, `req_mid` and `req_bus` are level inputs. They count only when they are high on a cycle with `boundary`=1.
- R10: A result appears only in the cycle after a boundary. It stays valid and unchanged until `take_ack`. Boundaries seen while a result is valid start no new decision.
- R11: The `status` bit layout is as follows. Bits [2:0] are the disable bits. Bit [3] is the global enable. Bit [4] is `req_lo`. Bit [5] is `req_mid`. Bit [6] is the `req_edge` pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_nmi | input | 1 | Non-maskable request, taken on a rise that is still high |
| req_edge | input | 1 | Edge-captured maskable request |
| req_mid | input | 1 | Level maskable request, middle rank |
| req_lo | input | 1 | Level maskable request, lowest vectored rank |
| req_bus | input | 1 | Level request for a bus-supplied instruction |
| boundary | input | 1 | Core is between instructions |
| mask_we | input | 1 | Write strobe for the disable register |
| mask_wdata | input | 4 | [2:0] disable bits, [3] clear edge pending |
| ie_set | input | 1 | Set the global enable |
| ie_clr | input | 1 | Clear the global enable |
| take_ack | input | 1 | Core has consumed the result |
| take_valid | output | 1 | A decision is waiting |
| take_vector | output | 16 | Restart address |
| take_push | output | 1 | Core must push the program counter |
| take_fetch | output | 1 | Core must fetch one instruction from the bus |
| status | output | 7 | Disable bits, enable, pending state |

## Verification
The embedded assertions check several rules on every cycle. A result never appears without a preceding boundary. It stays frozen until acknowledged. Push and fetch are exclusive. Nothing other than the non-maskable source is accepted while the enable flag was clear. Edge latches follow their inputs, and the priority grant is at most one-hot. Only the bench scenarios show the rest. These are the full priority order under every combination of requests, disable bits and enable, the exact vector values, the once-only behaviour of a held non-maskable request, and the fact that a short level pulse between boundaries is lost.

// File: rtl/vint_pkg.sv
// Shared constants for the interrupt unit.
// Assumes source indices are ordered by rising priority.
package vint_pkg;
    localparam int NSRC    = 5;
    localparam int IDX_BUS = 0;
    localparam int IDX_LO  = 1;
    localparam int IDX_MID = 2;
    localparam int IDX_HI  = 3;
    localparam int IDX_NMI = 4;
    localparam int NMASK   = 3;
    localparam int STAT_W  = NMASK + 4;
endpackage

// File: rtl/vint_edge_cap.sv
// Rising-edge capture latch.
// With QUALIFY=1 the latch also drops whenever the input is low, so a
// pulse that ends before it is consumed is forgotten.
// Assumes the input is already synchronous to clk.
module vint_edge_cap #(
    parameter bit QUALIFY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic pend
);
    logic din_q;
    logic rise;

    assign rise = din & ~din_q;

    // Delayed copy of the input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    generate
        if (QUALIFY) begin : g_qual
            // Latch a rise; drop on consume or when the input falls.
            always_ff @(posedge clk) begin
                if (!rst_n)            pend <= 1'b0;
                else if (rise)         pend <= 1'b1;
                else if (clr || !din)  pend <= 1'b0;
            end
            // R2: a low input never leaves the latch armed next cycle
            a_r2_low_disarms: assert property (@(posedge clk) disable iff (!rst_n)
                !din |=> !pend);
        end else begin : g_plain
            // Latch a rise; a new edge wins over a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)    pend <= 1'b0;
                else if (rise) pend <= 1'b1;
                else if (clr)  pend <= 1'b0;
            end
        end
    endgenerate

    // R8: every rising edge is remembered
    a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (din && !din_q) |=> pend);
endmodule

// File: rtl/vint_ctrl_regs.sv
// Per-source disable bits and the global enable flag.
// Assumes accept_mask pulses for one cycle per accepted maskable request.
module vint_ctrl_regs #(
    parameter int NM = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic [NM-1:0] mask_bits,
    input  logic          ie_set,
    input  logic          ie_clr,
    input  logic          accept_mask,
    output logic [NM-1:0] mask_q,
    output logic          gie_q
);
    // Disable bits: all sources blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_bits;
    end

    // Global enable: acceptance clears first, then explicit commands.
    always_ff @(posedge clk) begin
        if (!rst_n)           gie_q <= 1'b0;
        else if (accept_mask) gie_q <= 1'b0;
        else if (ie_clr)      gie_q <= 1'b0;
        else if (ie_set)      gie_q <= 1'b1;
    end

    // R7: a maskable acceptance always leaves the enable cleared
    a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        accept_mask |=> !gie_q);
    // R6: a mask write lands on the next cycle
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(mask_bits));
endmodule

// File: rtl/vint_prio.sv
// Fixed-priority picker: the highest set index wins.
// Purely combinational; assumes index order equals priority order.
module vint_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant
);
    // Scan from the top index down and keep the first hit.
    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // R5: at most one source is granted
    always_comb begin
        a_r5_single_grant: assert ($onehot0(grant));
    end
endmodule

// File: rtl/vint_unit.sv
// Prioritized vectored interrupt unit, top level.
// Samples eligible requests on a boundary and holds the winner in a
// result register until acknowledged. Assumes all inputs are synchronous.
module vint_unit #(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] VEC_NMI = 16'h0024,
    parameter logic [15:0] VEC_LO  = 16'h002C,
    parameter logic [15:0] VEC_MID = 16'h0034,
    parameter logic [15:0] VEC_HI  = 16'h003C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_nmi,
    input  logic              req_edge,
    input  logic              req_mid,
    input  logic              req_lo,
    input  logic              req_bus,
    input  logic              boundary,
    input  logic              mask_we,
    input  logic [3:0]        mask_wdata,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              take_ack,
    output logic              take_valid,
    output logic [ADDR_W-1:0] take_vector,
    output logic              take_push,
    output logic              take_fetch,
    output logic [6:0]        status
);
    import vint_pkg::*;

    logic [NMASK-1:0] mask_q;
    logic             gie_q;
    logic             nmi_arm;
    logic             hi_pend;
    logic [NSRC-1:0]  elig;
    logic [NSRC-1:0]  grant;
    logic             accept;
    logic             accept_mask;
    logic [ADDR_W-1:0] vec_sel;

    vint_ctrl_regs #(.NM(NMASK)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_we     (mask_we),
        .mask_bits   (mask_wdata[NMASK-1:0]),
        .ie_set      (ie_set),
        .ie_clr      (ie_clr),
        .accept_mask (accept_mask),
        .mask_q      (mask_q),
        .gie_q       (gie_q)
    );

    vint_edge_cap #(.QUALIFY(1'b1)) u_nmi_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (req_nmi),
        .clr   (accept && grant[IDX_NMI]),
        .pend  (nmi_arm)
    );

    vint_edge_cap #(.QUALIFY(1'b0)) u_hi_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (req_edge),
        .clr   ((accept && grant[IDX_HI]) || (mask_we && mask_wdata[3])),
        .pend  (hi_pend)
    );

    // Eligibility of each source at this cycle.
    always_comb begin
        elig          = '0;
        elig[IDX_NMI] = nmi_arm & req_nmi;
        elig[IDX_HI]  = gie_q & ~mask_q[2] & hi_pend;
        elig[IDX_MID] = gie_q & ~mask_q[1] & req_mid;
        elig[IDX_LO]  = gie_q & ~mask_q[0] & req_lo;
        elig[IDX_BUS] = gie_q & req_bus;
    end

    vint_prio #(.N(NSRC)) u_prio (
        .elig  (elig),
        .grant (grant)
    );

    assign accept      = boundary & ~take_valid & (|elig);
    assign accept_mask = accept & ~grant[IDX_NMI];

    // Restart address of the granted source.
    always_comb begin
        vec_sel = '0;
        if (grant[IDX_NMI])      vec_sel = VEC_NMI[ADDR_W-1:0];
        else if (grant[IDX_HI])  vec_sel = VEC_HI[ADDR_W-1:0];
        else if (grant[IDX_MID]) vec_sel = VEC_MID[ADDR_W-1:0];
        else if (grant[IDX_LO])  vec_sel = VEC_LO[ADDR_W-1:0];
    end

    // Result register: load on accept, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid  <= 1'b0;
            take_vector <= '0;
            take_push   <= 1'b0;
            take_fetch  <= 1'b0;
        end else if (accept) begin
            take_valid  <= 1'b1;
            take_vector <= vec_sel;
            take_push   <= ~grant[IDX_BUS];
            take_fetch  <= grant[IDX_BUS];
        end else if (take_valid && take_ack) begin
            take_valid  <= 1'b0;
            take_push   <= 1'b0;
            take_fetch  <= 1'b0;
        end
    end

    assign status = {hi_pend, req_mid, req_lo, gie_q, mask_q};

    // R10: a waiting result is frozen until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !take_ack) |=> (take_valid && $stable(take_vector)
                                       && $stable(take_fetch)));
    // R10: results only follow a boundary
    a_r10_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_valid) |-> $past(boundary));
    // R7: only the non-maskable source passes while the enable was clear
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_valid) && take_vector != VEC_NMI[ADDR_W-1:0]) |-> $past(gie_q));
    // R4: push and fetch are exclusive on a valid result
    a_r4_kind: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (take_push ^ take_fetch));
endmodule

// File: tb/test_vint_unit.sv
`timescale 1ns/1ps
module test_vint_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_nmi = 0, req_edge = 0, req_mid = 0, req_lo = 0, req_bus = 0;
    logic        boundary = 0, mask_we = 0, ie_set = 0, ie_clr = 0, take_ack = 0;
    logic [3:0]  mask_wdata = '0;
    logic        take_valid, take_push, take_fetch;
    logic [15:0] take_vector;
    logic [6:0]  status;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    vint_unit i_vint_unit (
        .clk(clk), .rst_n(rst_n), .req_nmi(req_nmi), .req_edge(req_edge),
        .req_mid(req_mid), .req_lo(req_lo), .req_bus(req_bus),
        .boundary(boundary), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ie_set(ie_set), .ie_clr(ie_clr), .take_ack(take_ack),
        .take_valid(take_valid), .take_vector(take_vector),
        .take_push(take_push), .take_fetch(take_fetch), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_reqs(input logic [4:0] r);
        {req_nmi, req_edge, req_mid, req_lo, req_bus} = r;
    endtask

    task automatic wr_mask(input logic [3:0] d);
        mask_we = 1; mask_wdata = d; cyc(); mask_we = 0;
    endtask

    task automatic enable(input bit on);
        ie_set = on; ie_clr = !on; cyc(); ie_set = 0; ie_clr = 0;
    endtask

    task automatic bound();
        boundary = 1; cyc(); boundary = 0;
    endtask

    task automatic ack();
        take_ack = 1; cyc(); take_ack = 0;
    endtask

    function automatic logic [15:0] vec_of(input int w);
        case (w)
            4: return 16'h0024;
            3: return 16'h003C;
            2: return 16'h0034;
            1: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1;
        cyc();
        // R1: reset state
        chk("R1 valid", take_valid, 0);
        chk("R1 status", status, 7'b000_0111);

        // Sweep: enable x disable bits x request set (R2..R8, R11)
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 8; m++) begin
                for (int r = 0; r < 32; r++) begin
                    int w;
                    logic [2:0] mm;
                    logic [4:0] rr;
                    mm = m[2:0]; rr = r[4:0];
                    set_reqs(5'b0); cyc();
                    mask_we = 1; mask_wdata = {1'b1, mm};
                    ie_set = g[0]; ie_clr = !g[0];
                    cyc();
                    mask_we = 0; ie_set = 0; ie_clr = 0;
                    set_reqs({rr[4], rr[3], rr[2], rr[1], rr[0]});
                    cyc(); cyc();
                    chk("R11 status before", status, {rr[3], rr[2], rr[1], g[0], mm});
                    w = -1;
                    if (rr[4]) w = 4;
                    else if (g != 0) begin
                        if (rr[3] && !mm[2])      w = 3;
                        else if (rr[2] && !mm[1]) w = 2;
                        else if (rr[1] && !mm[0]) w = 1;
                        else if (rr[0])           w = 0;
                    end
                    bound();
                    // R5 R6 R7: winner selection
                    chk("R5 valid", take_valid, (w >= 0));
                    if (w >= 0) begin
                        chk("R3 vector", take_vector, vec_of(w));
                        chk("R4 fetch", take_fetch, (w == 0));
                        chk("R2 push", take_push, (w != 0));
                        // R7 enable cleared by maskable accept; R8 pending kept unless won
                        chk("R7 R8 status after", status,
                            {(w == 3) ? 1'b0 : rr[3], rr[2], rr[1],
                             (w == 4) ? g[0] : 1'b0, mm});
                        ack();
                        chk("R10 cleared by ack", take_valid, 0);
                    end
                end
            end
        end
        set_reqs(5'b0); cyc();

        // R9: level pulse between boundaries is lost, level at boundary is taken
        wr_mask(4'b1000); enable(1);
        req_lo = 1; cyc(); req_lo = 0; cyc();
        bound();
        chk("R9 pulse lost", take_valid, 0);
        req_lo = 1; boundary = 1; cyc(); boundary = 0; req_lo = 0;
        chk("R9 level at boundary", take_vector, 16'h002C);
        chk("R9 valid", take_valid, 1);
        ack();

        // R10: hold and ignore boundaries while valid
        enable(1);
        req_mid = 1; bound(); req_mid = 0;
        req_nmi = 1; boundary = 1;
        cyc(); cyc(); cyc();
        boundary = 0;
        chk("R10 held valid", take_valid, 1);
        chk("R10 held vector", take_vector, 16'h0034);
        ack();
        chk("R10 no accept while valid", take_valid, 0);
        enable(1);
        bound();
        chk("R2 armed after wait", take_vector, 16'h0024);
        chk("R7 nmi keeps enable", status[3], 1);
        ack();
        bound();
        chk("R2 held request once", take_valid, 0);
        req_nmi = 0; cyc();
        req_nmi = 1; cyc(); req_nmi = 0; cyc();
        bound();
        chk("R2 dropped pulse", take_valid, 0);

        // R7: explicit clear blocks maskable sources
        enable(0);
        req_lo = 1; cyc(); bound(); req_lo = 0;
        chk("R7 disabled", take_valid, 0);

        // R8: edge latched while disabled, taken later after level gone
        wr_mask(4'b0100); enable(1);
        req_edge = 1; cyc(); req_edge = 0; cyc();
        chk("R8 latched while masked", status[6], 1);
        bound();
        chk("R6 masked edge blocked", take_valid, 0);
        wr_mask(4'b0000);
        bound();
        chk("R8 taken later", take_vector, 16'h003C);
        ack();
        enable(1);
        req_edge = 1; cyc(); req_edge = 0; cyc();
        wr_mask(4'b1000);
        chk("R8 cleared by write", status[6], 0);
        bound();
        chk("R8 nothing after clear", take_valid, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule